// File: doc/BRIEF.md
# Sticky Input-Change Flags with Masked Interrupt

This block watches a bank of asynchronous input pins and records any change on them. Each pin has its own sticky flag. A flag sets when the pin's synchronised level differs from a stored reference snapshot. The flag stays set even if the pin goes back to its earlier level before anyone looks. An enable mask picks which flags may pull the shared interrupt low. The interrupt is active-low and open-drain in style: low means asserted and high means released.

A serial slave drives the block with two single-cycle strobes. The snapshot strobe marks the moment the slave captures the port data, and the reference reloads from the current inputs at that moment. The clear strobe marks the end of a bus access, at STOP or at the acknowledge. On a clear, each flag reloads with "differs from the last snapshot". A change that happens between data capture and the end of the access is therefore kept. When both strobes arrive in the same cycle, only an edge seen in that very cycle survives. Changes are sensed after a two-stage synchroniser. For the first few cycles after reset the block only primes its reference, so levels already present at reset are never flagged.

Top module: `edge_flag_irq`

## Requirements
- R1: A level change on a pin sets that pin's flag bit. The flag becomes visible after the third rising clock edge following the change. A change must be held for at least two cycles to be captured.
- R2: A set flag stays set while no clear strobe is given, even after the pin returns to its earlier level.
- R3: A clear strobe given while the pins are stable and equal to the snapshot makes all flags zero after the next edge, and the interrupt is released.
- R4: When the clear and snapshot strobes are high together in the same cycle as a newly synchronised edge on a pin, that pin's flag is set after the edge instead of cleared.
- R5: `irq_n` is low exactly when some flag bit is set whose bit in `irq_en` is 1. The mask never alters the flags. With an all-zero mask, `irq_n` stays high.
- R6: The snapshot strobe reloads the reference without touching the flags. A clear strobe alone leaves a flag set for every pin whose level now differs from the last snapshot.
- R7: After reset the flags are zero and `irq_n` is high. Pin levels present at reset are not reported as changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | W | Raw asynchronous input pins |
| irq_en_i | input | W | Interrupt enable mask, 1 = pin may interrupt |
| clr_i | input | 1 | One-cycle strobe at the end of any bus access |
| snap_i | input | 1 | One-cycle strobe when port data is captured |
| flags_o | output | W | Sticky change flags |
| irq_n_o | output | 1 | Active-low interrupt, high = released |

## Verification
Some properties are checked on every cycle. A difference from the snapshot is always absorbed into the flags. Flags never drop without a clear. A combined clear and snapshot keeps exactly the current edges. Flags stay zero while priming, and a zero mask keeps the interrupt released. Other behaviours depend on timing and can only be shown by the bench's directed scenarios: a short pulse that has already gone away but is still flagged, a change that falls between snapshot and clear, and the edge that meets a clear in the same cycle. Random pin, mask and strobe traffic is compared cycle by cycle against a bench model.

// File: rtl/edge_flag_irq.sv
module edge_flag_irq #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] irq_en_i,
  input  logic         clr_i,
  input  logic         snap_i,
  output logic [W-1:0] flags_o,
  output logic         irq_n_o
);
  localparam int WARM = SYNC + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic [W-1:0]  sync_r [SYNC];
  logic [W-1:0]  sync_q, prev_q, ref_q, flags_q;
  logic [CW-1:0] warm_q;
  logic          armed;
  logic [W-1:0]  diff, edge_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_r[i] <= '0;
    end else begin
      sync_r[0] <= pins_i;
      for (int i = 1; i < SYNC; i++) sync_r[i] <= sync_r[i-1];
    end
  end

  assign sync_q = sync_r[SYNC-1];
  assign armed  = (warm_q == CW'(WARM));
  assign diff   = sync_q ^ ref_q;
  assign edge_v = sync_q ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (!armed) warm_q <= warm_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      ref_q   <= '0;
      flags_q <= '0;
    end else begin
      prev_q <= sync_q;
      if (!armed || snap_i || clr_i) ref_q <= sync_q;
      if (!armed)                flags_q <= '0;
      else if (clr_i && snap_i)  flags_q <= edge_v;
      else if (clr_i)            flags_q <= diff;
      else                       flags_q <= flags_q | diff;
    end
  end

  assign flags_o = flags_q;
  assign irq_n_o = ~|(flags_q & irq_en_i);
endmodule

// File: rtl/edge_flag_irq_chk.sv
module edge_flag_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         snap,
  input logic [W-1:0] mask,
  input logic [W-1:0] flags,
  input logic         irq_n,
  input logic [W-1:0] sync_q,
  input logic [W-1:0] prev_q,
  input logic [W-1:0] ref_q,
  input logic         armed
);
  assert_diff_absorbed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr) |=> ((flags & $past(sync_q ^ ref_q)) == $past(sync_q ^ ref_q)));

  assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr) |=> ((flags & $past(flags)) == $past(flags)));

  assert_clear_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clr && snap) |=> ($countones(flags) <= $countones($past(sync_q ^ prev_q))));

  assert_edge_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clr && snap) |=> ((flags & $past(sync_q ^ prev_q)) == $past(sync_q ^ prev_q)));

  assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_n);

  assert_since_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clr && !snap) |=> ((flags & $past(sync_q ^ ref_q)) == $past(sync_q ^ ref_q)));

  assert_quiet_priming_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (flags == '0));
endmodule

bind edge_flag_irq edge_flag_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr_i), .snap(snap_i), .mask(irq_en_i),
  .flags(flags_q), .irq_n(irq_n_o), .sync_q(sync_q), .prev_q(prev_q),
  .ref_q(ref_q), .armed(armed)
);

// File: tb/edge_flag_irq_tb.sv
module edge_flag_irq_tb;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pins = 8'hA5;
  logic [W-1:0] mask = 8'hFF;
  logic clr = 1'b0, snap = 1'b0;
  logic [W-1:0] flags;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_flag_irq #(.W(W), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .irq_en_i(mask),
    .clr_i(clr), .snap_i(snap), .flags_o(flags), .irq_n_o(irq_n)
  );

  logic [W-1:0] m_s0, m_s1, m_prev, m_ref, m_flags;
  int m_warm;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= '0; m_s1 <= '0; m_prev <= '0; m_ref <= '0; m_flags <= '0; m_warm <= 0;
    end else begin
      m_s0 <= pins; m_s1 <= m_s0; m_prev <= m_s1;
      if (m_warm < 3) begin
        m_warm <= m_warm + 1; m_ref <= m_s1; m_flags <= '0;
      end else begin
        if (clr || snap) m_ref <= m_s1;
        if (clr && snap) m_flags <= m_s1 ^ m_prev;
        else if (clr)    m_flags <= m_s1 ^ m_ref;
        else             m_flags <= m_flags | (m_s1 ^ m_ref);
      end
    end
  end

  function automatic logic exp_irq_n(input logic [W-1:0] f, input logic [W-1:0] m);
    return ~|(f & m);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit model_on = 1'b0;
  always @(negedge clk) if (rst_n && model_on && !done) begin
    chk(flags == m_flags, "R1 flags vs model", flags, m_flags);
    chk(irq_n == exp_irq_n(m_flags, mask), "R5 irq vs model", irq_n, exp_irq_n(m_flags, mask));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit c, input bit s);
    clr = c; snap = s;
    @(negedge clk);
    clr = 1'b0; snap = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    chk(flags == 8'h00, "R7 flags after reset", flags, 8'h00);
    chk(irq_n == 1'b1, "R7 irq after reset", irq_n, 1);

    pins = 8'hA4; cyc(2); pins = 8'hA5; cyc(5);
    chk(flags == 8'h01, "R2 transient kept", flags, 8'h01);
    chk(irq_n == 1'b0, "R5 irq asserted", irq_n, 0);

    pulse(1, 0);
    chk(flags == 8'h00, "R3 clear", flags, 8'h00);
    chk(irq_n == 1'b1, "R3 irq released", irq_n, 1);

    pins = 8'hA7;
    @(negedge clk); @(negedge clk);
    chk(flags == 8'h00, "R1 not before third edge", flags, 8'h00);
    @(negedge clk);
    chk(flags == 8'h02, "R1 latency", flags, 8'h02);
    mask = 8'h00; @(negedge clk);
    chk(irq_n == 1'b1 && flags == 8'h02, "R5 zero mask", {flags, irq_n}, {8'h02, 1'b1});
    mask = 8'h02; @(negedge clk);
    chk(irq_n == 1'b0, "R5 enabled bit", irq_n, 0);
    mask = 8'hFD; @(negedge clk);
    chk(irq_n == 1'b1, "R5 other bits", irq_n, 1);
    mask = 8'hFF;
    pulse(1, 1);
    chk(flags == 8'h00, "R3 clear with snapshot", flags, 8'h00);

    pins = 8'hA3;
    @(negedge clk); @(negedge clk);
    pulse(1, 1);
    chk(flags == 8'h04, "R4 edge wins over clear", flags, 8'h04);
    cyc(2);
    chk(flags == 8'h04, "R4 no re-flag after", flags, 8'h04);

    pulse(1, 1);
    pins = 8'hAB; cyc(4);
    chk(flags == 8'h08, "R6 change seen", flags, 8'h08);
    pulse(0, 1);
    chk(flags == 8'h08, "R6 snapshot keeps flags", flags, 8'h08);
    pins = 8'hA3; cyc(4);
    pulse(1, 0);
    chk(flags == 8'h08, "R6 change since snapshot kept", flags, 8'h08);
    pulse(1, 1);
    chk(flags == 8'h00, "R3 final clear", flags, 8'h00);

    model_on = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 6 == 0) pins = pins ^ (8'h01 << ($urandom % 8));
      if ($urandom % 50 == 0) mask = 8'($urandom);
      clr  = ($urandom % 16 == 0);
      snap = ($urandom % 12 == 0);
      @(negedge clk);
    end
    clr = 1'b0; snap = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule